// File: doc/BRIEF.md
# Serial Flash Command Front End with Sector Lock Read

This block is the target side of a single-lane SPI serial flash command port in clock mode 0. It runs on the chip's own clock and oversamples the serial pins. It collects an 8-bit instruction and, where the instruction needs one, a 24-bit address. It then serves five operations:

- a read of the per-sector lock byte;
- a write of that byte;
- setting of the write-enable latch;
- a read of the status byte;
- a write of the status byte, gated by the software and hardware protection modes.

A busy flag from an outside program or erase engine blocks lock reads and all committed writes. Raising chip select ends any command at once.

The serial output is a data bit plus an enable. The pad ring turns these into a tri-state pin. The serial pins have no flow control: the host sets the pace with the serial clock and ends a command by deselecting. Inside the block there are no stalls and no back-pressure. A byte that is being read out repeats for as long as the host keeps clocking.

Top module: `flash_lockreg_slave`

## Requirements
- R1: After reset `sdo_en` is 0, the status byte reads 0x00 and every sector's lock byte reads 0x00.
- R2: `sdo_en` is 1 only during an accepted output phase. Within 6 clocks of `cs_n` going high it is 0, and it stays 0 for any other command.
- R3: Opcode 0xE8 followed by a 24-bit MSB-first address returns the addressed sector's 8-bit lock byte, MSB first. The byte repeats while clocking continues.
- R4: The sector index is address bits 22:16 (128 sectors). Bit 23 and bits 15:0 do not affect the selection.
- R5: If `busy` is 1 when the 0xE8 opcode completes, the read is rejected and `sdo_en` stays 0 for the whole command.
- R6: Input bits are taken on rising `sck`. Output bits change only after falling `sck` and are stable while `sck` is high.
- R7: Opcode 0x06 sets the write-enable latch when `cs_n` rises after exactly 8 bits.
- R8: Opcode 0x05 returns the status byte, repeated. Bit 7 is protect-enable, bit 6 is block-protect 3, bit 5 is top/bottom, bits 4:2 are block-protect 2..0, bit 1 is the write-enable latch and bit 0 is `busy`.
- R9: Opcode 0x01 plus one data byte loads status bits 7:2 only if all of these hold when `cs_n` rises:
  - exactly 16 bits have been clocked in;
  - the write-enable latch is set;
  - `busy` is 0;
  - the block is in software mode, meaning bit 7 is 0 or `wp_n` is 1.
- R10: In hardware mode (status bit 7 is 1 and `wp_n` is 0), a status write changes no status bit.
- R11: The write-enable latch clears when `cs_n` rises after a complete 0x01 or 0xE5 opcode, whether or not the write took effect.
- R12: Opcode 0xE5 followed by a 24-bit address and a data byte stores the byte in the addressed sector's lock byte. It does so only if exactly 40 bits were clocked in, the write-enable latch is set and `busy` is 0 when `cs_n` rises.
- R13: An unknown opcode is ignored until `cs_n` rises. Raising `cs_n` during output ends the command, and the next command then works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Program/erase/write cycle in progress, synchronous to clk |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for the data-out pad (0 = high impedance) |

## Verification
Hardware mode is the hardest state to reach from the ports. Protect-enable must first be written to 1 while the block is still in software mode. The bench then lowers `wp_n`, sets the write-enable latch, and attempts a status write that must leave every bit unchanged. The busy rejections need `busy` held across the whole command, including opcode completion. Abort behaviour is reached by deselecting a lock read in the middle of its output byte. Ignored writes are checked by reading back through 0x05 and 0xE8.

// File: rtl/flash_lr_pkg.sv
package flash_lr_pkg;
  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OP_WREN = 8'h06;
  localparam logic [OP_W-1:0] OP_RDSR = 8'h05;
  localparam logic [OP_W-1:0] OP_WRSR = 8'h01;
  localparam logic [OP_W-1:0] OP_RDLK = 8'hE8;
  localparam logic [OP_W-1:0] OP_WRLK = 8'hE5;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_DIN,
    PH_OUT,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_STATUS,
    SRC_LOCK
  } src_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic csn_s,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic wp_n_s
);
  localparam int PIN_N = 4;
  localparam logic [PIN_N-1:0] PIN_RST = 4'b1001;

  logic [PIN_N-1:0] pipe [STAGES];
  logic sck_d, csn_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[g] <= PIN_RST;
        else        pipe[g] <= {cs_n, sck, mosi, wp_n};
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[g] <= PIN_RST;
        else        pipe[g] <= pipe[g-1];
    end
  end

  assign {csn_s, mosi_s, wp_n_s} = {pipe[STAGES-1][3], pipe[STAGES-1][1], pipe[STAGES-1][0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_d <= pipe[STAGES-1][2];
      csn_d <= csn_s;
    end
  end

  assign sck_rise = pipe[STAGES-1][2] & ~sck_d;
  assign sck_fall = ~pipe[STAGES-1][2] & sck_d;
  assign cs_rise  = csn_s & ~csn_d;
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import flash_lr_pkg::*;
#(
  parameter int ADDR_BITS   = 24,
  parameter int SECTOR_LSB  = 16,
  parameter int SECTOR_BITS = 7,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csn_s,
  input  logic                   sck_rise,
  input  logic                   mosi_s,
  input  logic                   busy,
  output phase_t                 phase,
  output src_t                   src,
  output logic [OP_W-1:0]        opcode,
  output logic [CNT_W-1:0]       bitcnt,
  output logic [SECTOR_BITS-1:0] sector,
  output logic [DATA_W-1:0]      data_byte
);
  localparam int SH_W = OP_W + ADDR_BITS;
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(OP_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(SH_W - 1);

  logic [SH_W-1:0] sreg, sh_next;
  assign sh_next   = {sreg[SH_W-2:0], mosi_s};
  assign data_byte = sreg[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_OPCODE;
      src    <= SRC_NONE;
      opcode <= '0;
      bitcnt <= '0;
      sector <= '0;
      sreg   <= '0;
    end else if (csn_s) begin
      phase  <= PH_OPCODE;
      src    <= SRC_NONE;
      opcode <= '0;
      bitcnt <= '0;
      sreg   <= '0;
    end else if (sck_rise) begin
      sreg <= sh_next;
      if (bitcnt != CNT_MAX) bitcnt <= bitcnt + 1'b1;
      unique case (phase)
        PH_OPCODE: if (bitcnt == OP_LAST) begin
          opcode <= sh_next[OP_W-1:0];
          unique case (sh_next[OP_W-1:0])
            OP_RDSR: begin phase <= PH_OUT; src <= SRC_STATUS; end
            OP_WRSR: phase <= PH_DIN;
            OP_RDLK: phase <= busy ? PH_SKIP : PH_ADDR;
            OP_WRLK: phase <= PH_ADDR;
            default: phase <= PH_SKIP;
          endcase
        end
        PH_ADDR: if (bitcnt == ADDR_LAST) begin
          sector <= sh_next[SECTOR_LSB+SECTOR_BITS-1:SECTOR_LSB];
          if (opcode == OP_RDLK) begin
            phase <= PH_OUT;
            src   <= SRC_LOCK;
          end else begin
            phase <= PH_DIN;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_lr_pkg::*;
#(
  parameter int ADDR_BITS = 24,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise,
  input  logic [OP_W-1:0]   opcode,
  input  logic [CNT_W-1:0]  bitcnt,
  input  logic [5:0]        din_hi,
  input  logic              busy,
  input  logic              wp_n_s,
  output logic [5:0]        prot,
  output logic              wel,
  output logic              hw_prot,
  output logic              lock_wr
);
  localparam logic [CNT_W-1:0] LEN_OP   = CNT_W'(OP_W);
  localparam logic [CNT_W-1:0] LEN_WRSR = CNT_W'(OP_W + DATA_W);
  localparam logic [CNT_W-1:0] LEN_WRLK = CNT_W'(OP_W + ADDR_BITS + DATA_W);

  logic sr_wr;

  assign hw_prot = prot[5] & ~wp_n_s;
  assign sr_wr   = cs_rise && (opcode == OP_WRSR) && (bitcnt == LEN_WRSR)
                   && wel && !busy && !hw_prot;
  assign lock_wr = cs_rise && (opcode == OP_WRLK) && (bitcnt == LEN_WRLK)
                   && wel && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot <= '0;
      wel  <= 1'b0;
    end else begin
      if (sr_wr) prot <= din_hi;
      if (cs_rise) begin
        if (opcode == OP_WREN && bitcnt == LEN_OP) wel <= 1'b1;
        else if (opcode == OP_WRSR || opcode == OP_WRLK) wel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lock_reg_table.sv
module lock_reg_table #(
  parameter int SECTOR_BITS = 7,
  parameter int DATA_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SECTOR_BITS-1:0] wr_sector,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [SECTOR_BITS-1:0] rd_sector,
  output logic [DATA_W-1:0]      rd_data
);
  localparam int DEPTH = 1 << SECTOR_BITS;

  logic [DATA_W-1:0] entry [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) entry[g] <= '0;
      else if (wr_en && wr_sector == SECTOR_BITS'(g)) entry[g] <= wr_data;
  end

  assign rd_data = entry[rd_sector];
endmodule

// File: rtl/spi_out_shifter.sv
module spi_out_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] load_val,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [IDX_W-1:0]  idx;
  logic              started, sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; idx <= '0; started <= 1'b0; sdo_q <= 1'b0;
    end else if (!active) begin
      sh <= '0; idx <= '0; started <= 1'b0; sdo_q <= 1'b0;
    end else if (sck_fall) begin
      started <= 1'b1;
      idx     <= idx + 1'b1;
      if (idx == '0) begin
        sdo_q <= load_val[DATA_W-1];
        sh    <= load_val << 1;
      end else begin
        sdo_q <= sh[DATA_W-1];
        sh    <= sh << 1;
      end
    end
  end

  assign sdo_en = started;
  assign sdo    = started & sdo_q;
endmodule

// File: rtl/flash_lockreg_slave.sv
module flash_lockreg_slave
  import flash_lr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BITS   = 24,
  parameter int SECTOR_LSB  = 16,
  parameter int SECTOR_BITS = 7,
  parameter int DATA_W      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  input  logic busy,
  output logic sdo,
  output logic sdo_en
);
  localparam int CNT_W = $clog2(OP_W + ADDR_BITS + DATA_W + 1) + 1;

  logic csn_s, cs_rise, sck_rise, sck_fall, mosi_s, wp_n_s;
  phase_t phase;
  src_t   src;
  logic [OP_W-1:0]        opcode;
  logic [CNT_W-1:0]       bitcnt;
  logic [SECTOR_BITS-1:0] sector;
  logic [DATA_W-1:0]      data_byte, lock_rd, load_val;
  logic [5:0]             prot;
  logic                   wel, hw_prot, lock_wr;
  logic [7:0]             status;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .wp_n(wp_n),
    .csn_s(csn_s), .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_s(mosi_s), .wp_n_s(wp_n_s)
  );

  spi_cmd_decoder #(
    .ADDR_BITS(ADDR_BITS), .SECTOR_LSB(SECTOR_LSB), .SECTOR_BITS(SECTOR_BITS),
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sck_rise(sck_rise), .mosi_s(mosi_s),
    .busy(busy), .phase(phase), .src(src), .opcode(opcode), .bitcnt(bitcnt),
    .sector(sector), .data_byte(data_byte)
  );

  flash_status_ctrl #(.ADDR_BITS(ADDR_BITS), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .opcode(opcode), .bitcnt(bitcnt),
    .din_hi(data_byte[DATA_W-1:DATA_W-6]), .busy(busy), .wp_n_s(wp_n_s),
    .prot(prot), .wel(wel), .hw_prot(hw_prot), .lock_wr(lock_wr)
  );

  lock_reg_table #(.SECTOR_BITS(SECTOR_BITS), .DATA_W(DATA_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(lock_wr), .wr_sector(sector), .wr_data(data_byte),
    .rd_sector(sector), .rd_data(lock_rd)
  );

  assign status   = {prot, wel, busy};
  assign load_val = (src == SRC_STATUS) ? DATA_W'(status) : lock_rd;

  spi_out_shifter #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .active(phase == PH_OUT && !csn_s),
    .sck_fall(sck_fall), .load_val(load_val), .sdo(sdo), .sdo_en(sdo_en)
  );
endmodule

// File: rtl/flash_lockreg_checker.sv
module flash_lockreg_checker
  import flash_lr_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csn_s,
  input logic             cs_rise,
  input logic             sck_fall,
  input logic             sdo,
  input logic             sdo_en,
  input logic [OP_W-1:0]  opcode,
  input logic [CNT_W-1:0] bitcnt,
  input logic             wel,
  input logic             hw_prot,
  input logic [5:0]       prot
);
  assert_sdo_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !sdo_en);

  assert_sdo_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && $past(sdo_en) && !$past(sck_fall)) |-> $stable(sdo));

  assert_wel_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && opcode == OP_WREN && bitcnt == CNT_W'(OP_W)) |=> wel);

  assert_hw_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && hw_prot) |=> $stable(prot));

  assert_wel_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && (opcode == OP_WRSR || opcode == OP_WRLK)) |=> !wel);
endmodule

bind flash_lockreg_slave flash_lockreg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .cs_rise(cs_rise), .sck_fall(sck_fall),
  .sdo(sdo), .sdo_en(sdo_en), .opcode(opcode), .bitcnt(bitcnt), .wel(wel),
  .hw_prot(hw_prot), .prot(prot)
);

// File: tb/tb_flash_lockreg_slave.sv
module tb_flash_lockreg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1, busy = 1'b0;
  logic sdo, sdo_en;

  int n_checks = 0, n_fail = 0, stable_err = 0, idle_cnt = 0;
  bit done = 1'b0;

  logic [5:0] m_prot = '0;
  logic       m_wel  = 1'b0;
  logic [7:0] m_lock [128];

  flash_lockreg_slave dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .busy(busy), .sdo(sdo), .sdo_en(sdo_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2: released output on every clock once deselected long enough
  always @(negedge clk) begin
    if (rst_n && cs_n) idle_cnt++; else idle_cnt = 0;
    if (idle_cnt >= 6) begin
      n_checks++;
      if (sdo_en !== 1'b0) begin
        n_fail++;
        $display("FAIL R2 idle enable actual=%0b expected=0", sdo_en);
      end
    end
  end

  task automatic xfer(input logic [63:0] tx, input int n,
                      output logic [63:0] rx, output int en_cnt);
    logic b;
    rx = '0; en_cnt = 0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HP) @(negedge clk);
      b = sdo;
      rx = {rx[62:0], b};
      en_cnt += (sdo_en === 1'b1) ? 1 : 0;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      if (sdo_en === 1'b1 && sdo !== b) stable_err++;
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*HP) @(negedge clk);
  endtask

  task automatic cmd(input logic [63:0] tx, input int n,
                     output logic [63:0] rx, output int en_cnt);
    sel(); xfer(tx, n, rx, en_cnt); desel();
  endtask

  function automatic logic [7:0] m_status();
    return {m_prot, m_wel, busy};
  endfunction

  task automatic do_wren();
    logic [63:0] rx; int en;
    cmd(64'h06, 8, rx, en);
    m_wel = 1'b1;
  endtask

  task automatic rdsr_check(input string req);
    logic [63:0] rx; int en;
    cmd(64'h05_0000, 24, rx, en);
    chk({req, " status"}, rx[15:0], {m_status(), m_status()});
    chk({req, " status enable"}, en, 16);
  endtask

  task automatic wrsr(input logic [7:0] d, input int n);
    logic [63:0] rx; int en;
    cmd({40'h0, 8'h01, d, 8'hA5} >> (24 - n), n, rx, en);
    if (n == 16 && m_wel && !busy && !(m_prot[5] && !wp_n)) m_prot = d[7:2];
    m_wel = 1'b0;
  endtask

  task automatic wrlk(input logic [23:0] a, input logic [7:0] d);
    logic [63:0] rx; int en;
    cmd({24'h0, 8'hE5, a, d}, 40, rx, en);
    if (m_wel && !busy) m_lock[a[22:16]] = d;
    m_wel = 1'b0;
  endtask

  task automatic rdlk_check(input logic [23:0] a, input string req);
    logic [63:0] rx; int en;
    cmd({16'h0, 8'hE8, a, 16'h0}, 48, rx, en);
    if (busy) begin
      chk({req, " rejected enable"}, en, 0);
    end else begin
      chk({req, " lock data"}, rx[15:0], {m_lock[a[22:16]], m_lock[a[22:16]]});
      chk({req, " lock enable"}, en, 16);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] rx; int en;
    for (int i = 0; i < 128; i++) m_lock[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R1 reset enable", sdo_en, 0);
    rdsr_check("R1 R8");
    rdlk_check(24'h000000, "R1 R3");
    rdlk_check(24'h7F0000, "R1 R4");

    do_wren();
    rdsr_check("R7 R8");

    wrsr(8'h5C, 16);
    rdsr_check("R9 write accepted");
    wrsr(8'h20, 16);
    rdsr_check("R9 no latch");
    do_wren();
    wrsr(8'h20, 24);
    rdsr_check("R9 R11 long frame");
    do_wren();
    wrsr(8'h20, 12);
    rdsr_check("R9 R11 short frame");

    busy = 1'b1;
    do_wren();
    wrsr(8'h20, 16);
    rdsr_check("R9 R8 busy");
    busy = 1'b0;
    rdsr_check("R9 R11 after busy");

    do_wren();
    wrsr(8'hBC, 16);
    rdsr_check("R9 protect enable");
    wp_n = 1'b0;
    do_wren();
    wrsr(8'h00, 16);
    rdsr_check("R10 R11 hardware mode");
    wp_n = 1'b1;
    do_wren();
    wrsr(8'h08, 16);
    rdsr_check("R9 software mode");

    do_wren();
    wrlk(24'h050000, 8'hA5);
    rdlk_check(24'h85ABCD, "R3 R4 R12 bit23 set");
    rdlk_check(24'h060000, "R4 next sector");
    rdlk_check(24'h04FFFF, "R4 prior sector");
    wrlk(24'h7F0000, 8'h3C);
    rdlk_check(24'hFF0000, "R12 no latch");
    do_wren();
    wrlk(24'hFFFFFF, 8'h3C);
    rdlk_check(24'h7F1234, "R3 R12 top sector");

    busy = 1'b1;
    rdlk_check(24'h050000, "R5 busy read");
    do_wren();
    wrlk(24'h050000, 8'h11);
    busy = 1'b0;
    rdlk_check(24'h050000, "R5 R12 busy write");

    cmd({24'h0, 8'h9F, 32'h0}, 40, rx, en);
    chk("R13 R2 unknown opcode enable", en, 0);
    rdsr_check("R13 after unknown");

    sel();
    xfer({29'h0, 8'hE8, 24'h050000, 3'b000}, 35, rx, en);
    chk("R13 partial output", rx[2:0], 3'b101);
    desel();
    chk("R13 R2 abort enable", sdo_en, 0);
    rdlk_check(24'h050000, "R13 after abort");

    chk("R6 stable while sck high", stable_err, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule